// File: doc/BRIEF.md
# Looping Context Sequencer

This block holds the configuration contexts of one processing cell in a coarse-grained reconfigurable array. A boot-time load port fills a small context store, 32 words of 40 bits by default. During execution a pointer walks a loop window between a start address and an end address supplied by a central controller. Each cycle the word at the pointer is read into a registered output, so the cell can take a new context every cycle without stalling.

When the pointer reaches the end of the window it jumps back to the start, and a 3-bit stage counter advances by one. The stage value is the rotation offset that the cell's local register file and predicate registers add to their addresses. A restart control puts the pointer back at the start address and clears the stage. Contexts are static while the sequencer runs: writes presented in that state are dropped.

Top module: `ctx_loop_seq`

## Requirements
- R1: When `run` is low and `load_en` is high, `load_data` is stored at word `load_addr` on the clock edge. Any of the 32 words can be read back later.
- R2: While reset is asserted, `ctx_addr` is 0, `stage` is 0 and `ctx_word` is all zeros.
- R3: When `run` is high, `restart` is low and `ctx_addr` differs from `end_addr`, `ctx_addr` rises by one on each edge. It wraps from 31 to 0 when the end has not yet been reached.
- R4: When `run` is high, `restart` is low and `ctx_addr` equals `end_addr`, the next `ctx_addr` is `start_addr` and `stage` increments modulo 8. At no other time does `stage` increase.
- R5: `restart` high loads `start_addr` into `ctx_addr` and clears `stage` to 0 on the next edge, whatever the level of `run`.
- R6: With `run` and `restart` both low, `ctx_addr` and `stage` hold their values.
- R7: With `rd_en` high, `ctx_word` after an edge equals the stored word at the `ctx_addr` value present before that edge. This gives one cycle of latency and a new word each cycle.
- R8: With `rd_en` low, `ctx_word` holds its previous value.
- R9: A load presented while `run` is high leaves the addressed word unchanged.
- R10: When `start_addr` equals `end_addr` and the sequencer runs, `ctx_addr` stays put and `stage` advances on every edge, returning from 7 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Boot load strobe |
| load_addr | input | 5 | Word index to load |
| load_data | input | 40 | Context word to load |
| rd_en | input | 1 | Read enable for the context output register |
| run | input | 1 | Advance the loop pointer each cycle |
| restart | input | 1 | Return to start address and clear stage |
| start_addr | input | 5 | First word of the loop window |
| end_addr | input | 5 | Last word of the loop window |
| ctx_word | output | 40 | Registered context word |
| ctx_addr | output | 5 | Current loop pointer |
| stage | output | 3 | Kernel pass counter (register rotation offset) |

## Verification
The bench runs a window that crosses the top of the store (30 to 1). A pointer that jumps to the start at 31 or compares with the wrong width would leave the expected sequence there. A window of a single word runs long enough for the stage to pass 7. This exposes a stage that saturates, or one that only moves when the address changes. A restart is issued while `run` is high, so a design that gives priority to stepping would advance instead. Loads are attempted mid-run and then read back, and `rd_en` is dropped mid-loop, to catch a store that takes writes during execution and an output that keeps following the pointer.

// File: rtl/ctx_seq_pkg.sv
package ctx_seq_pkg;
  // Operation picked for the loop pointer each cycle
  typedef enum logic [1:0] {
    PTR_HOLD    = 2'd0,
    PTR_STEP    = 2'd1,
    PTR_WRAP    = 2'd2,
    PTR_RESTART = 2'd3
  } ptr_op_e;
endpackage

// File: rtl/ctx_ptr.sv
module ctx_ptr
  import ctx_seq_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int STAGE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               restart,
  input  logic [ADDR_W-1:0]  start_addr,
  input  logic [ADDR_W-1:0]  end_addr,
  output logic [ADDR_W-1:0]  ptr,
  output logic [STAGE_W-1:0] stage
);
  ptr_op_e             op;
  logic [ADDR_W-1:0]   ptr_d;
  logic [STAGE_W-1:0]  stage_d;
  logic                ptr_en;

  // Operation select: restart has priority over stepping
  always_comb begin
    if (restart)                op = PTR_RESTART;
    else if (!run)              op = PTR_HOLD;
    else if (ptr == end_addr)   op = PTR_WRAP;
    else                        op = PTR_STEP;
  end

  // Next-state values
  always_comb begin
    ptr_d   = ptr;
    stage_d = stage;
    unique case (op)
      PTR_RESTART: begin
        ptr_d   = start_addr;
        stage_d = '0;
      end
      PTR_WRAP: begin
        ptr_d   = start_addr;
        stage_d = stage + STAGE_W'(1);
      end
      PTR_STEP: begin
        ptr_d   = ptr + ADDR_W'(1);
      end
      default: begin
        ptr_d   = ptr;
        stage_d = stage;
      end
    endcase
  end

  assign ptr_en = (op != PTR_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr   <= '0;
      stage <= '0;
    end else if (ptr_en) begin
      ptr   <= ptr_d;
      stage <= stage_d;
    end
  end
endmodule

// File: rtl/ctx_store.sv
module ctx_store #(
  parameter int ADDR_W = 5,
  parameter int CTX_W  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CTX_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CTX_W-1:0]  rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [CTX_W-1:0] words [DEPTH];
  logic [CTX_W-1:0] rd_sel;

  // One storage word per decoded address
  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    logic             hit;
    logic [CTX_W-1:0] word_q;

    assign hit = wr_en && (wr_addr == ADDR_W'(w));

    always_ff @(posedge clk) begin
      if (hit) word_q <= wr_data;
    end

    assign words[w] = word_q;
  end

  assign rd_sel = words[rd_addr];

  // Registered read, held when not enabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_en)  rd_data <= rd_sel;
  end
endmodule

// File: rtl/ctx_loop_seq.sv
module ctx_loop_seq #(
  parameter int ADDR_W  = 5,
  parameter int CTX_W   = 40,
  parameter int STAGE_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_en,
  input  logic [ADDR_W-1:0]  load_addr,
  input  logic [CTX_W-1:0]   load_data,
  input  logic               rd_en,
  input  logic               run,
  input  logic               restart,
  input  logic [ADDR_W-1:0]  start_addr,
  input  logic [ADDR_W-1:0]  end_addr,
  output logic [CTX_W-1:0]   ctx_word,
  output logic [ADDR_W-1:0]  ctx_addr,
  output logic [STAGE_W-1:0] stage
);
  logic store_wr;

  // Contexts are frozen while the pointer runs
  assign store_wr = load_en && !run;

  ctx_ptr #(.ADDR_W(ADDR_W), .STAGE_W(STAGE_W)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .restart    (restart),
    .start_addr (start_addr),
    .end_addr   (end_addr),
    .ptr        (ctx_addr),
    .stage      (stage)
  );

  ctx_store #(.ADDR_W(ADDR_W), .CTX_W(CTX_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (store_wr),
    .wr_addr (load_addr),
    .wr_data (load_data),
    .rd_en   (rd_en),
    .rd_addr (ctx_addr),
    .rd_data (ctx_word)
  );
endmodule

// File: rtl/ctx_loop_seq_chk.sv
module ctx_loop_seq_chk #(
  parameter int ADDR_W  = 5,
  parameter int CTX_W   = 40,
  parameter int STAGE_W = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               rd_en,
  input logic               run,
  input logic               restart,
  input logic [ADDR_W-1:0]  start_addr,
  input logic [ADDR_W-1:0]  end_addr,
  input logic [CTX_W-1:0]   ctx_word,
  input logic [ADDR_W-1:0]  ctx_addr,
  input logic [STAGE_W-1:0] stage
);
  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart && ctx_addr != end_addr)
      |=> (ctx_addr == ADDR_W'($past(ctx_addr) + ADDR_W'(1))) && $stable(stage));

  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !restart && ctx_addr == end_addr)
      |=> (ctx_addr == $past(start_addr)) &&
          (stage == STAGE_W'($past(stage) + STAGE_W'(1))));

  // R5
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (ctx_addr == $past(start_addr)) && (stage == '0));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(ctx_addr) && $stable(stage));

  // R8
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(ctx_word));
endmodule

bind ctx_loop_seq ctx_loop_seq_chk #(
  .ADDR_W(ADDR_W), .CTX_W(CTX_W), .STAGE_W(STAGE_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .rd_en      (rd_en),
  .run        (run),
  .restart    (restart),
  .start_addr (start_addr),
  .end_addr   (end_addr),
  .ctx_word   (ctx_word),
  .ctx_addr   (ctx_addr),
  .stage      (stage)
);

// File: tb/ctx_loop_seq_test.sv
`timescale 1ns/1ps
module ctx_loop_seq_test;
  localparam int AW = 5;
  localparam int CW = 40;
  localparam int SW = 3;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          load_en;
  logic [AW-1:0] load_addr;
  logic [CW-1:0] load_data;
  logic          rd_en;
  logic          run;
  logic          restart;
  logic [AW-1:0] start_addr;
  logic [AW-1:0] end_addr;
  logic [CW-1:0] ctx_word;
  logic [AW-1:0] ctx_addr;
  logic [SW-1:0] stage;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // Reference state built from the requirements
  logic [CW-1:0] m_mem [DEPTH];
  logic [AW-1:0] m_ptr;
  logic [SW-1:0] m_stage;
  logic [CW-1:0] m_word;

  always #5 clk = ~clk;

  ctx_loop_seq uut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
    .load_data(load_data), .rd_en(rd_en), .run(run), .restart(restart),
    .start_addr(start_addr), .end_addr(end_addr), .ctx_word(ctx_word),
    .ctx_addr(ctx_addr), .stage(stage)
  );

  function automatic logic [CW-1:0] pat(input int i);
    logic [31:0] lo;
    lo = 32'(i) * 32'h0100_0193 + 32'h811C_9DC5;
    return {8'(i) ^ 8'hA5, lo};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Advance one clock: update the model from current inputs, then compare
  task automatic step(input string req);
    logic [CW-1:0] w_n;
    w_n = rd_en ? m_mem[m_ptr] : m_word;
    if (load_en && !run) m_mem[load_addr] = load_data;
    if (restart) begin
      m_ptr = start_addr; m_stage = '0;
    end else if (run) begin
      if (m_ptr == end_addr) begin
        m_ptr = start_addr; m_stage = m_stage + SW'(1);
      end else begin
        m_ptr = m_ptr + AW'(1);
      end
    end
    m_word = w_n;
    @(posedge clk); #1;
    check(ctx_addr === m_ptr, {req, " addr"}, 64'(ctx_addr), 64'(m_ptr));
    check(stage === m_stage, {req, " stage"}, 64'(stage), 64'(m_stage));
    check(ctx_word === m_word, {req, " word"}, 64'(ctx_word), 64'(m_word));
  endtask

  task automatic idle_inputs();
    load_en = 0; load_addr = '0; load_data = '0; rd_en = 0;
    run = 0; restart = 0; start_addr = '0; end_addr = '0;
  endtask

  task automatic t_reset();
    idle_inputs();
    rst_n = 0;
    m_ptr = '0; m_stage = '0; m_word = '0;
    repeat (3) @(posedge clk);
    #1;
    check(ctx_addr === '0, "R2 addr", 64'(ctx_addr), 0);
    check(stage === '0, "R2 stage", 64'(stage), 0);
    check(ctx_word === '0, "R2 word", 64'(ctx_word), 0);
    rst_n = 1;
    step("R2 after release");
  endtask

  task automatic t_load_all();
    for (int i = 0; i < DEPTH; i++) begin
      load_en = 1; load_addr = AW'(i); load_data = pat(i);
      step("R1 R8 load");
    end
    load_en = 0;
  endtask

  task automatic t_loop();
    start_addr = 5'd3; end_addr = 5'd6; restart = 1; rd_en = 1;
    step("R5 restart");
    restart = 0; run = 1;
    for (int i = 0; i < 12; i++) step("R3 R4 R7 loop");
    run = 0;
  endtask

  task automatic t_top_wrap();
    start_addr = 5'd30; end_addr = 5'd1; restart = 1;
    step("R5 restart");
    restart = 0; run = 1;
    for (int i = 0; i < 10; i++) step("R3 R4 top wrap");
    run = 0;
  endtask

  task automatic t_single();
    start_addr = 5'd7; end_addr = 5'd7; restart = 1;
    step("R5 restart");
    restart = 0; run = 1;
    for (int i = 0; i < 10; i++) step("R10 single word");
    run = 0;
  endtask

  task automatic t_restart_mid();
    start_addr = 5'd12; end_addr = 5'd14; restart = 1;
    step("R5 restart");
    restart = 0; run = 1;
    repeat (5) step("R3 R4 pre-restart");
    restart = 1; start_addr = 5'd20;
    step("R5 restart beats run");
    restart = 0; end_addr = 5'd22;
    repeat (4) step("R3 after restart");
    run = 0;
  endtask

  task automatic t_hold();
    repeat (3) step("R6 hold");
  endtask

  task automatic t_rd_hold();
    start_addr = 5'd8; end_addr = 5'd11; restart = 1; rd_en = 1;
    step("R5 restart");
    restart = 0; run = 1;
    repeat (2) step("R7 read");
    rd_en = 0;
    repeat (4) step("R8 word held");
    rd_en = 1;
    repeat (2) step("R7 read resumes");
    run = 0;
  endtask

  task automatic t_write_ignored();
    start_addr = 5'd0; end_addr = 5'd31; restart = 1;
    step("R5 restart");
    restart = 0; run = 1;
    load_en = 1; load_addr = 5'd10; load_data = 40'hDEAD_BEEF_01;
    step("R9 write while running");
    load_addr = 5'd25; load_data = 40'hDEAD_BEEF_02;
    step("R9 write while running");
    load_en = 0; run = 0;
    // Read back both targets through the pointer
    start_addr = 5'd10; restart = 1; rd_en = 1;
    step("R5 restart");
    restart = 0;
    step("R9 word 10 unchanged");
    check(ctx_word === pat(10), "R9 word10", ctx_word, pat(10));
    start_addr = 5'd25; restart = 1;
    step("R5 restart");
    restart = 0;
    step("R9 word 25 unchanged");
    check(ctx_word === pat(25), "R9 word25", ctx_word, pat(25));
    // A load with run low does take effect
    load_en = 1; load_addr = 5'd25; load_data = 40'h12_3456_789A;
    step("R1 reload");
    load_en = 0;
    step("R1 read reload");
    check(ctx_word === 40'h12_3456_789A, "R1 reload word", ctx_word,
          40'h12_3456_789A);
  endtask

  initial begin
    t_reset();
    t_load_all();
    t_loop();
    t_top_wrap();
    t_single();
    t_restart_mid();
    t_hold();
    t_rd_hold();
    t_write_ignored();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule